// File: doc/BRIEF.md
# Linear page table translator

This block turns a 32-bit virtual address into a physical address by reading one entry of a single-level page table held in memory. Pages are 4 KB. The low 12 address bits are the byte offset within the page and pass through unchanged. The upper 20 bits are the virtual page number, so one table holds 2^20 entries. The table starts at a physical base address. The entry for page `n` is the 4-byte word at `base + 4*n`.

A request carries the virtual address, a write flag and an instruction-fetch flag. The translator handles one request at a time. It fetches the entry through a simple memory port and tests the entry's status bits. It then returns either the physical address or a fault code. On a successful access it sets the entry's referenced bit, and on a successful data write it also sets the dirty bit. It stores the entry back only when one of those two bits actually changes.

Entry layout: bits [31:12] hold the frame number, bit 0 is valid, bit 1 is present, bit 2 is writable, bit 3 is referenced and bit 4 is dirty. Bits [11:5] are carried through untouched.

Top module: `vpage_xlate`

## Requirements
- R1: On success (`rsp_fault` = 0) `rsp_paddr` equals the entry's bits [31:12] concatenated with virtual address bits [11:0].
- R2: The entry is read with exactly one memory read, at address `pt_base + 4*vaddr[31:12]`, where `pt_base` is the value sampled in the cycle the request is accepted.
- R3: An entry with bit 0 (valid) clear gives fault code 1, whatever its other bits are.
- R4: An entry with valid set and bit 1 (present) clear gives fault code 2, whatever its other bits are.
- R5: A data write to a valid, present entry with bit 2 (writable) clear gives fault code 3.
- R6: Any faulting access leaves the table untouched: no memory write is issued.
- R7: A successful access sets bit 3, and a successful data write also sets bit 4. All other bits of the entry are kept. The entry is written back once, at the address it was read from, and only if its value changed.
- R8: An access with `req_fetch` = 1 is a read: `req_write` is ignored, no protection fault is raised and bit 4 is not set.
- R9: `req_ready` is high only while the block is idle. `rsp_valid` is a one-cycle pulse. `rsp_paddr` is 0 whenever `rsp_fault` is non-zero.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request (address, write flag, write data) stays unchanged.
- R11: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_base | input | 32 | Physical start address of the current page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a data write |
| req_fetch | input | 1 | Access is an instruction fetch |
| rsp_valid | output | 1 | One-cycle result pulse |
| rsp_paddr | output | 32 | Translated physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 not present, 3 protection |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Entry value to store |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_rdata | input | 32 | Read data (page table entry) |

## Verification
Fault checking and status update are decided from the same returned entry in the same cycle. This means a check on the protection or valid bits can hide a bug in the update path, and the reverse is also true. The bench applies all 32 combinations of the five status bits under each of four access kinds: read, write, fetch, and fetch with write. Each result is judged against a fault code, an expected final table word, and an exact count of memory reads and writes, all computed arithmetically.

The memory model stalls its ready signal in a repeating pattern, so the write-back and the response are exercised behind back-pressure. The table base input is also changed right after acceptance on half the requests, to show that the base is captured when the request is taken.

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pt_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic              req_fetch,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [ADDR_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_rdata
);
  localparam int VPN_W = ADDR_W - OFF_W;

  typedef enum logic [2:0] {IDLE, RDREQ, RDWAIT, WRREQ, RESP} state_t;
  state_t state;

  logic [ADDR_W-1:0] base_q, vaddr_q, pte_q;
  logic              wr_q;
  logic [1:0]        fault_q;

  logic [1:0]        f_new;
  logic [ADDR_W-1:0] pte_upd;

  always_comb begin
    if (!mem_rsp_rdata[0])                   f_new = 2'd1;
    else if (!mem_rsp_rdata[1])              f_new = 2'd2;
    else if (wr_q && !mem_rsp_rdata[2])      f_new = 2'd3;
    else                                     f_new = 2'd0;
    pte_upd = mem_rsp_rdata | ADDR_W'(32'h8) | (wr_q ? ADDR_W'(32'h10) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      base_q  <= '0;
      vaddr_q <= '0;
      pte_q   <= '0;
      wr_q    <= 1'b0;
      fault_q <= 2'd0;
    end else begin
      case (state)
        IDLE: if (req_valid) begin
          base_q  <= pt_base;
          vaddr_q <= req_vaddr;
          wr_q    <= req_write && !req_fetch;
          state   <= RDREQ;
        end
        RDREQ: if (mem_req_ready) state <= RDWAIT;
        RDWAIT: if (mem_rsp_valid) begin
          fault_q <= f_new;
          pte_q   <= (f_new == 2'd0) ? pte_upd : mem_rsp_rdata;
          state   <= (f_new == 2'd0 && pte_upd != mem_rsp_rdata) ? WRREQ : RESP;
        end
        WRREQ: if (mem_req_ready) state <= RESP;
        default: state <= IDLE;
      endcase
    end
  end

  assign req_ready     = (state == IDLE);
  assign rsp_valid     = (state == RESP);
  assign rsp_fault     = rsp_valid ? fault_q : 2'd0;
  assign rsp_paddr     = (rsp_valid && fault_q == 2'd0) ?
                         {pte_q[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;
  assign mem_req_valid = (state == RDREQ) || (state == WRREQ);
  assign mem_req_write = (state == WRREQ);
  assign mem_req_addr  = base_q + {{(OFF_W-2){1'b0}}, vaddr_q[ADDR_W-1:OFF_W], 2'b00};
  assign mem_req_wdata = pte_q;

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> rsp_paddr == '0);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R6
  wb_only_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> (mem_req_wdata[0] && mem_req_wdata[1] && mem_req_wdata[3]));
  // R7
  wb_then_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_ready) |=> (rsp_valid && rsp_fault == 2'd0));
  // R2
  one_req_per_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (mem_req_valid && !mem_req_write));
endmodule

// File: tb/tb_vpage_xlate.sv
`timescale 1ns/1ps
module tb_vpage_xlate;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [31:0] pt_base = '0, req_vaddr = '0;
  logic req_valid = 0, req_write = 0, req_fetch = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic mem_req_valid, mem_req_write;
  logic mem_req_ready = 0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_rdata = '0;

  vpage_xlate dut (.*);

  logic [31:0] pt [64];
  logic [31:0] cur_base = '0;
  int n_rd = 0, n_wr = 0;
  logic [31:0] last_rd = '0, last_wr = '0;
  int cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        pt[6'((mem_req_addr - cur_base) >> 2)] <= mem_req_wdata;
        n_wr <= n_wr + 1;
        last_wr <= mem_req_addr;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= pt[6'((mem_req_addr - cur_base) >> 2)];
        n_rd <= n_rd + 1;
        last_rd <= mem_req_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xlate(input int idx, input logic [31:0] pte, input bit wr, input bit fe,
                       input logic [11:0] off, input bit scramble);
    logic [31:0] va, exp_pte, exp_pa, exp_addr;
    logic [1:0] exp_f;
    bit w;
    int rd0, wr0, t;
    va = {20'(idx), off};
    w = wr && !fe;
    exp_f = !pte[0] ? 2'd1 : !pte[1] ? 2'd2 : (w && !pte[2]) ? 2'd3 : 2'd0;
    exp_pte = (exp_f == 0) ? (pte | 32'h8 | (w ? 32'h10 : 32'h0)) : pte;
    exp_pa = (exp_f == 0) ? {pte[31:12], off} : 32'h0;
    exp_addr = cur_base + 32'(idx) * 4;
    pt[idx] = pte;
    @(negedge clk);
    rd0 = n_rd; wr0 = n_wr;
    pt_base = cur_base; req_vaddr = va; req_write = wr; req_fetch = fe; req_valid = 1;
    t = 0;
    while (!req_ready && t < 50) begin @(negedge clk); t++; end
    @(negedge clk);
    req_valid = 0;
    if (scramble) pt_base = 32'hDEAD_0000;
    t = 0;
    while (!rsp_valid && t < 60) begin
      chk(!req_ready, "R9 ready low while busy", 32'(req_ready), 0);
      @(negedge clk); t++;
    end
    chk(rsp_valid, "R9 response arrives", 32'(rsp_valid), 1);
    chk(rsp_fault == exp_f, exp_f == 1 ? "R3 invalid fault" : exp_f == 2 ? "R4 not-present fault" :
        exp_f == 3 ? "R5 protection fault" : (fe ? "R8 fetch treated as read" : "R5 no fault"),
        32'(rsp_fault), 32'(exp_f));
    chk(rsp_paddr == exp_pa, exp_f == 0 ? "R1 physical address" : "R9 zero address on fault",
        rsp_paddr, exp_pa);
    chk(n_rd - rd0 == 1 && last_rd == exp_addr, "R2 single read at base+4*vpn", last_rd, exp_addr);
    chk(pt[idx] == exp_pte, exp_f != 0 ? "R6 entry unchanged on fault" : (fe ? "R8 fetch sets no dirty" : "R7 status update"),
        pt[idx], exp_pte);
    chk(n_wr - wr0 == ((exp_pte != pte) ? 1 : 0), exp_f != 0 ? "R6 no write on fault" : "R7 write only on change",
        32'(n_wr - wr0), 32'((exp_pte != pte) ? 1 : 0));
    if (exp_pte != pte)
      chk(last_wr == exp_addr, "R7 write-back address", last_wr, exp_addr);
    @(negedge clk);
    chk(!rsp_valid, "R9 response is one pulse", 32'(rsp_valid), 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) pt[i] = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1, "R11 reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 0, "R11 reset rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req_valid == 0, "R11 reset mem_req_valid", 32'(mem_req_valid), 0);
    rst_n = 1;
    for (int b = 0; b < 2; b++) begin
      cur_base = b ? 32'h8000_1000 : 32'h0040_0000;
      for (int pat = 0; pat < 32; pat++)
        for (int acc = 0; acc < 4; acc++) begin
          int idx;
          logic [31:0] pte;
          idx = (pat * 4 + acc + b * 7) % 64;
          pte = {20'h5A000 + 20'(pat * 37 + acc * 5 + b), 7'(pat * 3 + b), 5'(pat)};
          xlate(idx, pte, acc[0], acc[1], 12'((pat * 131 + acc * 977 + b) & 12'hfff), (pat + acc) % 2 == 1);
        end
    end
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule